// File: doc/BRIEF.md
# Byte-Granular DMA Adapter for a Word-Only Bus

This block moves a stream of bytes between a local byte port and a 16-bit system bus. The bus can only read or write whole words, and only at even byte addresses. A transfer is described by a byte start address, a signed byte count and a direction. In the write direction the block takes bytes from a valid/ready input stream and stores them on the bus. When a transfer starts or ends in the middle of a word, it reads the word first and merges the new byte into it, so the neighbouring byte of that word keeps its old value. In the read direction the block fetches bus words and sends their bytes out in address order.

The bus side uses a request/acknowledge handshake with at most one access outstanding. An acknowledge that carries an error flag ends the transfer at once. A single-cycle done pulse closes every transfer, whether it completes normally, is aborted, or is empty. A status bit is reported with that pulse and tells an abort apart from a normal finish.

Top module: `byte_lane_dma`

## Requirements
- R1: A length of zero or a negative length (two's complement in `xfer_len`) makes no bus access. `done` is high in the second cycle after the accepted `start`, and `err` is 0.
- R2: In a write with an odd start address A, the block first reads the word at A-1. It then writes that word back to A-1 with bits 7:0 unchanged and the first stream byte in bits 15:8.
- R3: In a write, each aligned pair of bytes is stored with one bus write and no read. The earlier byte goes in bits 7:0 and the later byte in bits 15:8, and the next access address is 2 higher.
- R4: In a write, a final lone byte at an even address is stored with a read followed by a write. The write keeps bits 15:8 of the word read and puts the byte in bits 7:0.
- R5: An acknowledge with `bus_err` high ends the transfer. In the next cycle `done` and `err` are both 1. No further bus request is made and no further byte is delivered.
- R6: In a read with an odd start address A, the first byte delivered is bits 15:8 of the word at A-1.
- R7: In a read, each bus word delivers bits 7:0 first. It delivers bits 15:8 second only when more than one byte of the transfer remains. Bytes are delivered only in read transfers.
- R8: `busy` is high from the cycle after an accepted `start` until the transfer ends. `done` is high for exactly one cycle per transfer. A `start` while `busy` is high is ignored.
- R9: A bus request holds its address, direction and write data steady until acknowledged. Every bus address is even. The number of bus accesses is exactly the minimum that the rules R2 to R7 call for.
- R10: A write transfer never changes any byte outside the range from the start address up to (but not including) the start address plus the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted when not busy) |
| dir_write | input | 1 | 1: stream to bus, 0: bus to stream |
| xfer_addr | input | AW | Byte start address |
| xfer_len | input | LW | Signed byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Transfer aborted by a bus error (valid with done) |
| in_valid | input | 1 | Write-direction byte available |
| in_data | input | 8 | Write-direction byte |
| in_ready | output | 1 | Block takes in_data this cycle |
| out_valid | output | 1 | Read-direction byte valid (one cycle) |
| out_data | output | 8 | Read-direction byte |
| bus_req | output | 1 | Bus access requested |
| bus_we | output | 1 | 1: word write, 0: word read |
| bus_addr | output | AW | Even byte address of the word |
| bus_wdata | output | 16 | Word to write |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 16 | Word read, valid with bus_ack |
| bus_err | input | 1 | Access failed, valid with bus_ack |

## Verification
A wrong segment choice or a remaining-count that is off by one shows up at the bus port within one access. The result is an extra or missing read-modify-write, a byte in the wrong lane, or the wrong count of accesses. A model memory that is compared byte by byte after each transfer catches all of these. Sweeping every start offset within a few words, across lengths from negative to several words and in both directions, puts each end of a transfer on both odd and even addresses. Error injection at each access position shows that an abort stops the stream and the bus in the cycle after the failing acknowledge.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  // which part of a bus word the current access touches
  typedef enum logic [1:0] {
    SEG_HI   = 2'd0,   // upper byte only (odd address)
    SEG_FULL = 2'd1,   // both bytes
    SEG_LO   = 2'd2    // lower byte only (last byte, even address)
  } seg_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_BUSRD = 3'd2,
    ST_GET0  = 3'd3,
    ST_GET1  = 3'd4,
    ST_WRQ   = 3'd5,
    ST_BUSWR = 3'd6,
    ST_EMIT  = 3'd7
  } st_e;
endpackage

// File: rtl/bdma_cnt.sv
module bdma_cnt #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] ld_len,
  input  logic          adv,
  input  logic [1:0]    addr_step,
  input  logic [1:0]    len_step,
  output logic [AW-1:0] addr,
  output logic          odd,
  output logic          empty,
  output logic          multi
);
  logic [LW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      rem_q <= '0;
    end else if (load) begin
      addr  <= ld_addr;
      rem_q <= ld_len;
    end else if (adv) begin
      addr  <= addr + AW'(addr_step);
      rem_q <= rem_q - LW'(len_step);
    end
  end

  assign odd   = addr[0];
  assign empty = ($signed(rem_q) <= 0);
  assign multi = ($signed(rem_q) >= 2);

  // the sequencer only consumes bytes that are still owed
  assert_adv_nonempty_R9: assert property (@(posedge clk) disable iff (rst)
    adv |-> !empty);
endmodule

// File: rtl/bdma_lane.sv
module bdma_lane
  import bdma_pkg::*;
(
  input  seg_e              seg,
  input  logic [WORD_W-1:0] old_word,
  input  logic [BYTE_W-1:0] b0,
  input  logic [BYTE_W-1:0] b1,
  output logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_byte
);
  always_comb begin
    case (seg)
      SEG_HI:   wdata = {b0, old_word[BYTE_W-1:0]};
      SEG_FULL: wdata = {b1, b0};
      default:  wdata = {old_word[WORD_W-1:BYTE_W], b0};
    endcase
  end

  assign rd_byte = rd_hi ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
endmodule

// File: rtl/bdma_fsm.sv
module bdma_fsm
  import bdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_write,
  input  logic [AW-1:0]     cnt_addr,
  input  logic              cnt_odd,
  input  logic              cnt_empty,
  input  logic              cnt_multi,
  output logic              cnt_load,
  output logic              cnt_adv,
  output logic [1:0]        addr_step,
  output logic [1:0]        len_step,
  output seg_e              seg,
  output logic [WORD_W-1:0] old_word,
  output logic [BYTE_W-1:0] b0,
  output logic [BYTE_W-1:0] b1,
  input  logic [WORD_W-1:0] merged,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              rd_hi,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              err
);
  st_e  st;
  logic wr_mode;
  seg_e seg_nxt;
  logic acked_ok;
  logic [AW-1:0] even_addr;

  assign even_addr = {cnt_addr[AW-1:1], 1'b0};
  assign seg_nxt   = cnt_odd ? SEG_HI : (cnt_multi ? SEG_FULL : SEG_LO);
  assign acked_ok  = bus_req && bus_ack && !bus_err;
  assign in_ready  = (st == ST_GET0) || (st == ST_GET1);
  assign busy      = (st != ST_IDLE);
  assign rd_hi     = (seg == SEG_HI);

  always_comb begin
    cnt_load  = (st == ST_IDLE) && start;
    cnt_adv   = 1'b0;
    addr_step = 2'd2;
    len_step  = 2'd2;
    case (st)
      ST_BUSRD: if (acked_ok && !wr_mode && seg != SEG_FULL) begin
        cnt_adv   = 1'b1;
        addr_step = (seg == SEG_HI) ? 2'd1 : 2'd2;
        len_step  = 2'd1;
      end
      ST_EMIT: cnt_adv = 1'b1;
      ST_BUSWR: if (acked_ok) begin
        cnt_adv   = 1'b1;
        addr_step = (seg == SEG_FULL) ? 2'd2 : 2'd1;
        len_step  = (seg == SEG_FULL) ? 2'd2 : 2'd1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      wr_mode   <= 1'b0;
      seg       <= SEG_LO;
      old_word  <= '0;
      b0        <= '0;
      b1        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done      <= 1'b0;
      out_valid <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          wr_mode <= dir_write;
          err     <= 1'b0;
          st      <= ST_CHECK;
        end
        ST_CHECK: begin
          if (cnt_empty) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            seg <= seg_nxt;
            if (wr_mode && seg_nxt == SEG_FULL) begin
              st <= ST_GET0;
            end else begin
              bus_req  <= 1'b1;
              bus_we   <= 1'b0;
              bus_addr <= even_addr;
              st       <= ST_BUSRD;
            end
          end
        end
        ST_BUSRD: if (bus_ack) begin
          bus_req <= 1'b0;
          if (bus_err) begin
            err  <= 1'b1;
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            old_word <= bus_rdata;
            if (wr_mode) begin
              st <= ST_GET0;
            end else begin
              out_valid <= 1'b1;
              out_data  <= rd_byte;
              st        <= (seg == SEG_FULL) ? ST_EMIT : ST_CHECK;
            end
          end
        end
        ST_EMIT: begin
          out_valid <= 1'b1;
          out_data  <= old_word[WORD_W-1:BYTE_W];
          st        <= ST_CHECK;
        end
        ST_GET0: if (in_valid) begin
          b0 <= in_data;
          st <= (seg == SEG_FULL) ? ST_GET1 : ST_WRQ;
        end
        ST_GET1: if (in_valid) begin
          b1 <= in_data;
          st <= ST_WRQ;
        end
        ST_WRQ: begin
          bus_req   <= 1'b1;
          bus_we    <= 1'b1;
          bus_addr  <= even_addr;
          bus_wdata <= merged;
          st        <= ST_BUSWR;
        end
        ST_BUSWR: if (bus_ack) begin
          bus_req <= 1'b0;
          if (bus_err) begin
            err  <= 1'b1;
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            st <= ST_CHECK;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                            && $stable(bus_wdata));

  assert_even_addr_R9: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !bus_addr[0]);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_abort_R5: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack && bus_err |=> done && err && !bus_req && !busy);

  assert_read_only_out_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !wr_mode);
endmodule

// File: rtl/byte_lane_dma.sv
module byte_lane_dma
  import bdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dir_write,
  input  logic [AW-1:0] xfer_addr,
  input  logic [LW-1:0] xfer_len,
  output logic          busy,
  output logic          done,
  output logic          err,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [15:0]   bus_rdata,
  input  logic          bus_err
);
  logic [AW-1:0]     cnt_addr;
  logic              cnt_odd, cnt_empty, cnt_multi, cnt_load, cnt_adv;
  logic [1:0]        addr_step, len_step;
  seg_e              seg;
  logic [WORD_W-1:0] old_word, merged;
  logic [BYTE_W-1:0] b0, b1, rd_byte;
  logic              rd_hi;

  bdma_cnt #(.AW(AW), .LW(LW)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .ld_addr(xfer_addr),
    .ld_len(xfer_len), .adv(cnt_adv), .addr_step(addr_step),
    .len_step(len_step), .addr(cnt_addr), .odd(cnt_odd),
    .empty(cnt_empty), .multi(cnt_multi)
  );

  bdma_lane u_lane (
    .seg(seg), .old_word(old_word), .b0(b0), .b1(b1), .wdata(merged),
    .rd_word(bus_rdata), .rd_hi(rd_hi), .rd_byte(rd_byte)
  );

  bdma_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .dir_write(dir_write),
    .cnt_addr(cnt_addr), .cnt_odd(cnt_odd), .cnt_empty(cnt_empty),
    .cnt_multi(cnt_multi), .cnt_load(cnt_load), .cnt_adv(cnt_adv),
    .addr_step(addr_step), .len_step(len_step), .seg(seg),
    .old_word(old_word), .b0(b0), .b1(b1), .merged(merged),
    .rd_byte(rd_byte), .rd_hi(rd_hi), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .busy(busy),
    .done(done), .err(err)
  );

  assert_empty_len_R1: assert property (@(posedge clk) disable iff (rst)
    start && !busy && ($signed(xfer_len) <= 0) |=> !bus_req ##1 (done && !bus_req && !err));
endmodule

// File: tb/byte_lane_dma_tb.sv
module byte_lane_dma_tb;
  localparam int AW = 8;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, dir_write = 1'b0;
  logic [AW-1:0] xfer_addr = '0;
  logic [LW-1:0] xfer_len = '0;
  logic busy, done, err, in_ready, out_valid, bus_req, bus_we;
  logic in_valid = 1'b1;
  logic [7:0] in_data = '0, out_data;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata = '0;
  logic bus_ack = 1'b0, bus_err = 1'b0;

  always #2 clk = ~clk;

  byte_lane_dma #(.AW(AW), .LW(LW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .dir_write(dir_write),
    .xfer_addr(xfer_addr), .xfer_len(xfer_len), .busy(busy), .done(done),
    .err(err), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  logic [7:0] mem [0:255];
  logic [7:0] obuf [0:63];
  int kidx, ocnt, nacc, ndone, lat, lat_cfg, err_idx, last_err;
  bit pend;
  int vectors = 0, fails = 0, cycles = 0;

  function automatic logic [7:0] fpat(int i);  return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] gpat(int k);  return 8'((k * 11 + 8'h90) & 255); endfunction

  function automatic int exp_acc(bit wr, int a, int l);
    int n = 0;
    if (l <= 0) return 0;
    if (a % 2 == 1) begin n += wr ? 2 : 1; l--; end
    if (wr) begin n += l / 2; if (l % 2 == 1) n += 2; end
    else n += (l + 1) / 2;
    return n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  // bus responder, byte source and byte sink, all acting at falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (pend) kidx++;
        in_data = gpat(kidx);
        pend = in_valid && in_ready;
        if (out_valid) begin
          if (ocnt < 64) obuf[ocnt] = out_data;
          ocnt++;
        end
        if (done) begin ndone++; last_err = err; end
        if (bus_ack) begin
          bus_ack = 1'b0;
          bus_err = 1'b0;
        end else if (bus_req) begin
          if (lat > 0) lat--;
          else begin
            lat = lat_cfg;
            bus_ack = 1'b1;
            if (nacc == err_idx) bus_err = 1'b1;
            else if (bus_we) begin
              mem[bus_addr]      = bus_wdata[7:0];
              mem[bus_addr + 1]  = bus_wdata[15:8];
            end else bus_rdata = {mem[bus_addr + 1], mem[bus_addr]};
            nacc++;
          end
        end
      end
    end
  end

  task automatic run(bit wr, int a, int l, int lt, int eidx, bit poke);
    int waited = 0;
    @(negedge clk); #1;
    for (int i = 0; i < 256; i++) mem[i] = fpat(i);
    kidx = 0; pend = 0; ocnt = 0; nacc = 0; ndone = 0; last_err = 0;
    lat_cfg = lt; lat = lt; err_idx = eidx;
    dir_write = wr; xfer_addr = AW'(a); xfer_len = LW'(l); start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    check(busy == 1'b1, "R8 busy", busy, 1);
    while (ndone == 0 && waited < 400) begin
      @(negedge clk); #1;
      waited++;
      if (poke && waited == 3) begin
        xfer_addr = 8'd40; xfer_len = 8'd2; start = 1'b1;
      end else start = 1'b0;
    end
    if (l <= 0) check(waited == 1, "R1 done latency", waited, 1);
    for (int i = 0; i < 4; i++) begin @(negedge clk); #1; end
    check(ndone == 1, "R8 done pulses", ndone, 1);
  endtask

  task automatic check_write(int a, int l, string tag);
    int bad_in = -1, bad_out = -1;
    for (int i = 0; i < 64; i++) begin
      if (i >= a && i < a + l) begin
        if (mem[i] !== gpat(i - a) && bad_in < 0) bad_in = i;
      end else if (mem[i] !== fpat(i) && bad_out < 0) bad_out = i;
    end
    check(bad_in < 0, tag, (bad_in < 0) ? 0 : int'(mem[bad_in]),
          (bad_in < 0) ? 0 : int'(gpat(bad_in - a)));
    check(bad_out < 0, "R10 outside range", (bad_out < 0) ? 0 : int'(mem[bad_out]),
          (bad_out < 0) ? 0 : int'(fpat(bad_out)));
  endtask

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    #1;
    check(busy == 0 && done == 0 && bus_req == 0 && out_valid == 0 && in_ready == 0,
          "R8 reset state", {busy, done, bus_req, out_valid, in_ready}, 0);
    rst = 1'b0;

    // sweep offsets, lengths and directions
    for (int wr = 0; wr < 2; wr++) begin
      for (int a = 0; a < 8; a++) begin
        for (int l = -1; l < 10; l++) begin
          run(wr[0], a, l, (a + l + 3) % 3, -1, 1'b0);
          check(last_err == 0, "R5 no error", last_err, 0);
          check(nacc == exp_acc(wr[0], a, l), "R9 access count", nacc, exp_acc(wr[0], a, l));
          if (l <= 0) tag = "R1";
          else if (wr == 1) tag = (a % 2 == 1) ? "R2" : ((l % 2 == 1) ? "R4" : "R3");
          else tag = (a % 2 == 1) ? "R6" : "R7";
          if (wr == 1) check_write(a, l, tag);
          else begin
            int bad = -1;
            for (int k = 0; k < l && k < 64; k++) if (obuf[k] !== fpat(a + k) && bad < 0) bad = k;
            check(ocnt == ((l > 0) ? l : 0), tag, ocnt, (l > 0) ? l : 0);
            check(bad < 0, tag, (bad < 0) ? 0 : int'(obuf[bad]), (bad < 0) ? 0 : int'(fpat(a + bad)));
          end
        end
      end
    end

    // start while busy is ignored (R8)
    run(1'b1, 1, 6, 2, -1, 1'b1);
    check_write(1, 6, "R8 start ignored");
    check(nacc == exp_acc(1'b1, 1, 6), "R8 access count after poke", nacc, exp_acc(1'b1, 1, 6));

    // bus error abort at every access position (R5)
    for (int e = 0; e < 5; e++) begin
      run(1'b1, 3, 6, 1, e, 1'b0);
      check(last_err == 1, "R5 write abort err", last_err, 1);
      check(nacc == e + 1, "R5 write abort accesses", nacc, e + 1);
    end
    for (int e = 0; e < 3; e++) begin
      int exp_bytes;
      exp_bytes = (e == 0) ? 0 : ((e == 1) ? 1 : 3);
      run(1'b0, 1, 5, 0, e, 1'b0);
      check(last_err == 1, "R5 read abort err", last_err, 1);
      check(nacc == e + 1, "R5 read abort accesses", nacc, e + 1);
      check(ocnt == exp_bytes, "R5 read abort bytes", ocnt, exp_bytes);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule